// File: doc/BRIEF.md
# UART Receive Queue with Trigger Threshold

This block sits between a UART's receive shift register and the host. Each character the shifter finishes is pushed in together with three status flags: parity error, framing error and break. The host reads the oldest character from the head of the queue. The head character and its flags are visible combinationally whenever the queue is not empty, and a pop strobe advances to the next character. The queue holds up to 16 entries. When the queue is disabled it behaves as a single holding register.

The block also contains the queue control register. Through it the host enables the queue, requests clears of the receive queue and of the transmit queue (the latter leaves the block as a one-cycle pulse), stores a DMA-mode bit, and picks the occupancy at which the trigger flag rises. A character that arrives with no room left is dropped, and an overrun pulse reports the loss. A character that completes in the same cycle as a clear survives the clear.

Top module: `uart_rx_queue`

## Requirements
- R1: After reset the queue is empty, the count is 0, trig, ovr and tx_clr are 0, and ctl_rdata reads 0x00 (queue disabled, threshold code 00).
- R2: With the queue enabled, characters and their flags leave in arrival order. The head is visible on rd_data/rd_perr/rd_ferr/rd_brk while empty is 0, and count tracks pushes minus pops.
- R3: With the queue enabled and 16 entries held, a pushed character with no pop in the same cycle is discarded and the 16 held entries are unchanged. ovr is high for exactly the one cycle after that push.
- R4: trig is 1 exactly when count is at least the threshold. ctl bits 7:6 set the threshold: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 16. While the queue is disabled the threshold is 1.
- R5: ctl_rdata returns bit 0 = enable, bit 3 = DMA mode and bits 7:6 = threshold code as last written. Bits 1, 2, 4 and 5 always read 0.
- R6: A control write with bit 1 set empties the receive queue. A character pushed in that same cycle is kept as the only entry.
- R7: tx_clr is high for one cycle after a control write that has bit 2 set or that clears both queues (R8). It stays 0 after any other write.
- R8: A control write that leaves bit 0 at 0, or that changes bit 0 from 0 to 1, empties the receive queue and pulses tx_clr. Writing bit 0 = 1 while the queue is already enabled, with bit 1 clear, keeps the contents.
- R9: With the queue disabled it holds at most one character. A second push without a pop is dropped with an ovr pulse, and the first character stays at the head.
- R10: A push and a pop in the same cycle on a full queue are both carried out, so count stays at 16.
- R11: A pop on an empty queue is ignored: count stays 0 and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control register readback |
| rx_push | input | 1 | Character complete from the shift register |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error flag of the character |
| rx_ferr | input | 1 | Framing error flag of the character |
| rx_brk | input | 1 | Break flag of the character |
| rd_pop | input | 1 | Host consumes the head entry |
| rd_data | output | 8 | Head character |
| rd_perr | output | 1 | Head parity error flag |
| rd_ferr | output | 1 | Head framing error flag |
| rd_brk | output | 1 | Head break flag |
| empty | output | 1 | Queue holds nothing |
| trig | output | 1 | Occupancy at or above threshold |
| ovr | output | 1 | One-cycle pulse after a dropped character |
| rx_count | output | 5 | Current occupancy |
| tx_clr | output | 1 | One-cycle transmit queue clear pulse |

## Verification
The assertions assume that rx_push and rd_pop are single-cycle strobes that carry meaning only while reset is released. They also assume that a control write and a push in the same cycle mean a character landed during a clear, which the block keeps. The bench changes inputs only on the falling edge and holds each strobe for one clock. It pops only after it has checked the head. It combines a control write with a push on purpose only in the clear-with-arrival case.

// File: rtl/uart_rx_queue_pkg.sv
package uart_rx_queue_pkg;

  // One queue entry: flags above the character.
  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rxq_ent_t;

  // Stored control fields.
  typedef struct packed {
    logic [1:0] lvl;
    logic       dma;
    logic       en;
  } rxq_cfg_t;

  // Occupancy threshold for a level code, as a fraction of the depth.
  function automatic int unsigned lvl_bytes(input logic [1:0] code, input int unsigned depth);
    case (code)
      2'b00:   return 1;
      2'b01:   return depth / 4;
      2'b10:   return depth / 2;
      default: return depth;
    endcase
  endfunction

  // Readback image: pulse and reserved positions read as zero.
  function automatic logic [7:0] cfg_image(input rxq_cfg_t c);
    return {c.lvl, 2'b00, c.dma, 2'b00, c.en};
  endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import uart_rx_queue_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] wdata,
  output rxq_cfg_t   cfg,
  output logic       rx_flush,
  output logic       tx_clr
);
  logic clear_both;
  logic tx_req;
  logic unused_rsvd;

  assign unused_rsvd = ^wdata[5:4];

  // Writing 0 to enable, or switching enable on, clears both queues.
  assign clear_both = ~wdata[0] | ~cfg.en;
  assign rx_flush   = wr & (wdata[1] | clear_both);
  assign tx_req     = wr & (wdata[2] | clear_both);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      tx_clr <= 1'b0;
    end else begin
      tx_clr <= tx_req;
      if (wr) begin
        cfg.en  <= wdata[0];
        cfg.dma <= wdata[3];
        cfg.lvl <= wdata[7:6];
      end
    end
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import uart_rx_queue_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          cap_one,
  input  logic          push,
  input  rxq_ent_t      push_ent,
  input  logic          pop,
  output rxq_ent_t      head,
  output logic [CW-1:0] count,
  output logic          drop,
  output logic          ovr
);
  // DEPTH must be a power of two so the pointers wrap naturally.
  rxq_ent_t      mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr, wa;
  logic          full, pop_ok, take;

  assign full   = cap_one ? (count != '0) : (count == CW'(DEPTH));
  assign pop_ok = pop & (count != '0) & ~flush;
  assign take   = push & (~full | pop_ok | flush);
  assign drop   = push & ~take;
  assign wa     = flush ? '0 : wr_ptr;
  assign head   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (take) mem[wa] <= push_ent;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
      ovr    <= 1'b0;
    end else begin
      ovr <= drop;
      if (flush) begin
        rd_ptr <= '0;
        wr_ptr <= AW'(take);
        count  <= CW'(take);
      end else begin
        wr_ptr <= wr_ptr + AW'(take);
        rd_ptr <= rd_ptr + AW'(pop_ok);
        case ({take, pop_ok})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
    end
  end
endmodule

// File: rtl/rxq_thresh.sv
module rxq_thresh
  import uart_rx_queue_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  rxq_cfg_t      cfg,
  input  logic [CW-1:0] count,
  output logic          trig
);
  logic [CW-1:0] thr;
  assign thr  = cfg.en ? CW'(lvl_bytes(cfg.lvl, DEPTH)) : CW'(1);
  assign trig = (count >= thr);
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rx_queue_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [7:0]    ctl_wdata,
  output logic [7:0]    ctl_rdata,
  input  logic          rx_push,
  input  logic [7:0]    rx_data,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          rx_brk,
  input  logic          rd_pop,
  output logic [7:0]    rd_data,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic          rd_brk,
  output logic          empty,
  output logic          trig,
  output logic          ovr,
  output logic [CW-1:0] rx_count,
  output logic          tx_clr
);
  rxq_cfg_t cfg;
  rxq_ent_t in_ent, head;
  logic     rx_flush, drop_evt, fifo_en;

  assign in_ent  = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};
  assign fifo_en = cfg.en;

  rxq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctl_wr), .wdata(ctl_wdata),
    .cfg(cfg), .rx_flush(rx_flush), .tx_clr(tx_clr)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .cap_one(~fifo_en),
    .push(rx_push), .push_ent(in_ent), .pop(rd_pop),
    .head(head), .count(rx_count), .drop(drop_evt), .ovr(ovr)
  );

  rxq_thresh #(.DEPTH(DEPTH)) u_thr (
    .cfg(cfg), .count(rx_count), .trig(trig)
  );

  assign ctl_rdata = cfg_image(cfg);
  assign empty     = (rx_count == '0);
  assign rd_data   = head.data;
  assign rd_perr   = head.perr;
  assign rd_ferr   = head.ferr;
  assign rd_brk    = head.brk;
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_push,
  input logic          rd_pop,
  input logic          ctl_wr,
  input logic          empty,
  input logic          trig,
  input logic          ovr,
  input logic [CW-1:0] rx_count,
  input logic          fifo_en,
  input logic          rx_flush,
  input logic          drop_evt
);
  // R3
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CW'(DEPTH));

  // R9
  single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> rx_count <= CW'(1));

  // R3
  drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (ovr && rx_count == $past(rx_count)));

  // R11
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && empty && !rx_push && !ctl_wr) |=> empty);

  // R4
  trig_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> !empty);

  // R6
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |=> rx_count == CW'($past(rx_push)));
endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rd_pop(rd_pop),
  .ctl_wr(ctl_wr), .empty(empty), .trig(trig), .ovr(ovr),
  .rx_count(rx_count), .fifo_en(fifo_en), .rx_flush(rx_flush),
  .drop_evt(drop_evt)
);

// File: tb/sim_uart_rx_queue.sv
`timescale 1ns/1ps
module sim_uart_rx_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_wr = 1'b0;
  logic [7:0]  ctl_wdata = '0;
  logic [7:0]  ctl_rdata;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
  logic        rd_pop = 1'b0;
  logic [7:0]  rd_data;
  logic        rd_perr, rd_ferr, rd_brk;
  logic        empty, trig, ovr, tx_clr;
  logic [4:0]  rx_count;
  int          total = 0, bad = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  uart_rx_queue u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .rx_push(rx_push), .rx_data(rx_data),
    .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rd_pop(rd_pop),
    .rd_data(rd_data), .rd_perr(rd_perr), .rd_ferr(rd_ferr), .rd_brk(rd_brk),
    .empty(empty), .trig(trig), .ovr(ovr), .rx_count(rx_count), .tx_clr(tx_clr)
  );

  // Vector: op[18:17] (0 ctl write, 1 push, 2 pop), arg[16:6] = {brk,ferr,perr,data}
  // (ctl data in arg[7:0]; for pop, expected head), count[5:1], trig[0].
  localparam int NV = 20;
  localparam logic [18:0] VEC [NV] = '{
    {2'd0, 11'h041, 5'd0, 1'b0},
    {2'd1, 11'h011, 5'd1, 1'b0},
    {2'd1, 11'h122, 5'd2, 1'b0},
    {2'd1, 11'h233, 5'd3, 1'b0},
    {2'd1, 11'h444, 5'd4, 1'b1},
    {2'd2, 11'h011, 5'd3, 1'b0},
    {2'd0, 11'h001, 5'd3, 1'b1},
    {2'd2, 11'h122, 5'd2, 1'b1},
    {2'd2, 11'h233, 5'd1, 1'b1},
    {2'd2, 11'h444, 5'd0, 1'b0},
    {2'd0, 11'h081, 5'd0, 1'b0},
    {2'd1, 11'h050, 5'd1, 1'b0},
    {2'd1, 11'h151, 5'd2, 1'b0},
    {2'd1, 11'h252, 5'd3, 1'b0},
    {2'd1, 11'h453, 5'd4, 1'b0},
    {2'd1, 11'h754, 5'd5, 1'b0},
    {2'd1, 11'h055, 5'd6, 1'b0},
    {2'd1, 11'h056, 5'd7, 1'b0},
    {2'd1, 11'h057, 5'd8, 1'b1},
    {2'd2, 11'h050, 5'd7, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int head_val();
    return {rd_brk, rd_ferr, rd_perr, rd_data};
  endfunction

  // Called at a falling edge; returns at the next falling edge with strobes low.
  task automatic cyc(input logic w, input logic [7:0] wd, input logic p,
                     input logic [10:0] e, input logic pp);
    ctl_wr = w; ctl_wdata = wd; rx_push = p; rd_pop = pp;
    {rx_brk, rx_ferr, rx_perr, rx_data} = e;
    @(posedge clk);
    @(negedge clk);
    ctl_wr = 1'b0; rx_push = 1'b0; rd_pop = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", rx_count, 0);
    chk("R1 empty", empty, 1);
    chk("R1 trig", trig, 0);
    chk("R1 ovr", ovr, 0);
    chk("R1 rdata", ctl_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 tx_clr", tx_clr, 0);

    // Table walk: R2 order and flags, R4 thresholds
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [10:0] arg;
      op  = VEC[i][18:17];
      arg = VEC[i][16:6];
      if (op == 2'd2) begin
        chk("R2 head", head_val(), arg);
        cyc(1'b0, 8'h00, 1'b0, '0, 1'b1);
      end else if (op == 2'd1) begin
        cyc(1'b0, 8'h00, 1'b1, arg, 1'b0);
      end else begin
        cyc(1'b1, arg[7:0], 1'b0, '0, 1'b0);
      end
      chk("R2 count", rx_count, VEC[i][5:1]);
      chk("R4 trig", trig, VEC[i][0]);
    end

    // R5 readback, bit 1 clears, bit 2 pulses tx_clr
    cyc(1'b1, 8'hFF, 1'b0, '0, 1'b0);
    chk("R5 readback", ctl_rdata, 8'hC9);
    chk("R6 flushed", rx_count, 0);
    chk("R7 tx_clr pulse", tx_clr, 1);
    cyc(1'b0, 8'h00, 1'b0, '0, 1'b0);
    chk("R7 tx_clr one cycle", tx_clr, 0);

    // R3 fill to 16 at threshold 16
    for (int i = 0; i < 16; i++) begin
      cyc(1'b0, 8'h00, 1'b1, 11'((i % 8) << 8 | (i * 3 + 1)), 1'b0);
      if (i == 14) chk("R4 trig below 16", trig, 0);
    end
    chk("R4 trig at 16", trig, 1);
    chk("R3 full count", rx_count, 16);
    cyc(1'b0, 8'h00, 1'b1, 11'h0AA, 1'b0);
    chk("R3 ovr pulse", ovr, 1);
    chk("R3 count kept", rx_count, 16);
    cyc(1'b0, 8'h00, 1'b0, '0, 1'b0);
    chk("R3 ovr cleared", ovr, 0);

    // R10 push and pop on full
    chk("R10 head before", head_val(), 11'h001);
    cyc(1'b0, 8'h00, 1'b1, 11'h0BB, 1'b1);
    chk("R10 count", rx_count, 16);
    chk("R10 no ovr", ovr, 0);
    for (int i = 1; i < 17; i++) begin
      int exp;
      exp = (i == 16) ? 11'h0BB : ((i % 8) << 8 | (i * 3 + 1));
      chk("R3 contents order", head_val(), exp);
      cyc(1'b0, 8'h00, 1'b0, '0, 1'b1);
    end
    chk("R2 drained", empty, 1);

    // R11 pop when empty
    cyc(1'b0, 8'h00, 1'b0, '0, 1'b1);
    chk("R11 count", rx_count, 0);
    chk("R11 empty", empty, 1);
    cyc(1'b0, 8'h00, 1'b1, 11'h066, 1'b0);
    chk("R11 no underflow", rx_count, 1);
    chk("R11 head", head_val(), 11'h066);

    // R6 clear with a simultaneous arrival, enable kept
    cyc(1'b0, 8'h00, 1'b1, 11'h067, 1'b0);
    cyc(1'b1, 8'h03, 1'b1, 11'h35C, 1'b0);
    chk("R6 count", rx_count, 1);
    chk("R6 head", head_val(), 11'h35C);
    chk("R7 no tx_clr", tx_clr, 0);
    chk("R5 readback", ctl_rdata, 8'h01);

    // R8 keep contents when re-writing enable
    cyc(1'b1, 8'h01, 1'b0, '0, 1'b0);
    chk("R8 kept", rx_count, 1);
    chk("R8 no tx_clr", tx_clr, 0);

    // R8 write 0 to enable
    cyc(1'b1, 8'h00, 1'b0, '0, 1'b0);
    chk("R8 cleared", rx_count, 0);
    chk("R8 tx_clr", tx_clr, 1);
    chk("R1 rdata", ctl_rdata, 0);

    // R9 single holding register
    cyc(1'b0, 8'h00, 1'b1, 11'h021, 1'b0);
    chk("R9 count", rx_count, 1);
    chk("R4 trig disabled", trig, 1);
    cyc(1'b0, 8'h00, 1'b1, 11'h022, 1'b0);
    chk("R9 ovr", ovr, 1);
    chk("R9 count", rx_count, 1);
    chk("R9 head", head_val(), 11'h021);
    cyc(1'b0, 8'h00, 1'b0, '0, 1'b1);
    chk("R9 popped", empty, 1);

    // R8 enabling from disabled clears
    cyc(1'b0, 8'h00, 1'b1, 11'h030, 1'b0);
    cyc(1'b1, 8'h01, 1'b0, '0, 1'b0);
    chk("R8 enable clears", rx_count, 0);
    chk("R8 enable tx_clr", tx_clr, 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule